// File: doc/BRIEF.md
# Pseudo-SRAM Configuration Register Programmer

This block writes one of the two configuration words of a pseudo-SRAM. One word sets up the bus: synchronous or asynchronous operation, the latency code and the drive strength. The other sets up refresh: page-mode enable and the fraction of the array that is refreshed. The block sits between the chip's boot logic and the memory pins. After reset it holds the memory idle for a programmable number of clocks. This covers the device's power-up settling time. Only then does it accept a programming request.

A request names a method, a target word and a 16-bit value. The sideband method issues a single write cycle with the configuration-enable pin high, and the value and the target select travel on the address pins. The in-band method issues four ordinary array cycles to the highest address: two reads, then a write whose data code picks the target, then a write that carries the value. After the last cycle ends, a done flag rises. A shadow copy of both words is updated at that moment, and decoded fields from the shadow copy go to downstream controllers.

The request interface is valid/ready. A requester holds `req_valid` and its fields steady until it sees `req_ready` high at a rising edge. That edge is the transfer. `req_ready` stays low throughout the power-up wait and while a sequence is running. Fields that change after the transfer have no effect.

Top module: `cfgreg_prog`

## Requirements
- R1: During the first INIT_CYCLES rising edges after reset release, `req_ready` is low and `mem_ce_n` stays high. From edge INIT_CYCLES on, `req_ready` is high while the block is idle.
- R2: A request is taken on a rising edge with `req_valid` and `req_ready` both high. Method, select and value are captured on that edge, and later changes to them do not alter the cycles issued. `req_ready` is low until the sequence is finished, and an idle block issues no cycle while `req_valid` is low.
- R3: Sideband method (`req_use_seq`=0): the block issues exactly one write with `mem_cre`=1. The address is set as follows: A19 is the select (1 = bus word, 0 = refresh word), A18:16 are zero and A15:0 carry the value. `mem_dq_oe` stays low throughout.
- R4: In-band method (`req_use_seq`=1): the block issues four cycles with `mem_cre`=0, all at address FFFFFh, in this order: read, read, write of 0001h (bus word) or 0000h (refresh word), then write of the value with `mem_dq_oe` high. The third write's data is never any other code.
- R5: In every write, `mem_we_n` rises while `mem_ce_n` and `mem_adv_n` are still low, so the write-enable edge comes first. `mem_be_n` is 00 while `mem_ce_n` is low. `mem_ce_n` goes high between cycles, so each cycle is a separate chip-enable cycle.
- R6: `done` is low from the transfer edge until the last cycle has ended with `mem_ce_n` high. It then rises and stays high until the next transfer.
- R7: The shadow words reset to BUS_RESET (9D4Fh) on `bus_cfg` and REF_RESET (0010h) on `ref_cfg`. When `done` rises, the selected word takes the value and the other word is unchanged. Neither word changes at any other time.
- R8: The decoded outputs are `cfg_sync` = NOT `bus_cfg`[15], `cfg_latency` = `bus_cfg`[13:11], `cfg_drive_low` = `bus_cfg`[5], `cfg_page_en` = `ref_cfg`[7] and `cfg_par` = `ref_cfg`[2:0].
- R9: `mem_we_n` and `mem_oe_n` are never low together, and `mem_oe_n` goes low only in the reads of the in-band method.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_use_seq | input | 1 | 1 = in-band four-cycle method, 0 = sideband pin write |
| req_sel_bus | input | 1 | 1 = bus word, 0 = refresh word |
| req_value | input | 16 | Word to program |
| mem_addr | output | 20 | Memory address pins |
| mem_dq_out | output | 16 | Data driven to the memory |
| mem_dq_oe | output | 1 | Data output enable |
| mem_cre | output | 1 | Configuration-enable pin |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte enables, active low |
| done | output | 1 | Last sequence completed |
| bus_cfg | output | 16 | Shadow of the bus word |
| ref_cfg | output | 16 | Shadow of the refresh word |
| cfg_sync | output | 1 | Synchronous mode selected |
| cfg_latency | output | 3 | Latency code |
| cfg_drive_low | output | 1 | Reduced drive strength selected |
| cfg_page_en | output | 1 | Page mode enabled |
| cfg_par | output | 3 | Partial-array refresh select |

## Verification
The bench sweeps both methods, both targets and a set of values that includes all-zero, all-one, the bus reset word and every single-bit word. A bus monitor rebuilds each memory cycle from the pins. The sweeps target several faults, each with its own symptom. An A19 select that is swapped or missing would program the wrong word in the sideband write. A selector code with the wrong polarity, or a value placed in the third in-band write, would lead the memory to overwrite its top address. The bench also changes the request fields right after the transfer, which exposes a design that does not capture its request. Ending the power-up wait one edge early, or updating a shadow word outside the done edge, also shows up at the ports.

// File: rtl/cfgprog_pkg.sv
package cfgprog_pkg;

  localparam int MEM_AW       = 20;
  localparam int MEM_DW       = 16;
  localparam int SEL_ADDR_BIT = 19;

  localparam int BUS_MODE_BIT = 15;
  localparam int BUS_LAT_HI   = 13;
  localparam int BUS_LAT_LO   = 11;
  localparam int BUS_DRV_BIT  = 5;
  localparam int REF_PAGE_BIT = 7;
  localparam int REF_PAR_HI   = 2;

  localparam int SEQ_CYCLES   = 4;
  localparam int IDX_W        = $clog2(SEQ_CYCLES);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_STROBE,
    PH_HOLD,
    PH_GAP
  } phase_t;

  typedef enum logic {
    SQ_IDLE,
    SQ_RUN
  } seq_state_t;

  typedef struct packed {
    logic              is_wr;
    logic              cre;
    logic [MEM_AW-1:0] addr;
    logic [MEM_DW-1:0] data;
  } mem_op_t;

endpackage

// File: rtl/cfgprog_init_timer.sv
module cfgprog_init_timer #(
  parameter int INIT_CYCLES = 15000
) (
  input  logic clk,
  input  logic rst_n,
  output logic init_done
);
  localparam int CW = $clog2(INIT_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      init_done <= 1'b0;
    end else if (!init_done) begin
      if (cnt == CW'(INIT_CYCLES - 1)) begin
        init_done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgprog_cycle_engine.sv
module cfgprog_cycle_engine
  import cfgprog_pkg::*;
#(
  parameter int STROBE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mem_op_t           op,
  output logic              idle,
  output logic              cyc_done,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [MEM_DW-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              mem_cre,
  output logic              mem_ce_n,
  output logic              mem_adv_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [1:0]        mem_be_n
);
  localparam int CW = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;

  phase_t        ph;
  logic [CW-1:0] cnt;
  mem_op_t       op_q;
  logic          active;
  logic          strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      cnt  <= '0;
      op_q <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (start) begin
            op_q <= op;
            ph   <= PH_ADDR;
          end
        end
        PH_ADDR: begin
          cnt <= CW'(STROBE_CYCLES - 1);
          ph  <= PH_STROBE;
        end
        PH_STROBE: begin
          if (cnt == '0) begin
            ph <= PH_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: ph <= PH_GAP;
        PH_GAP:  ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    active     = (ph == PH_ADDR) || (ph == PH_STROBE) || (ph == PH_HOLD);
    strobe     = (ph == PH_STROBE);
    idle       = (ph == PH_IDLE);
    cyc_done   = (ph == PH_GAP);
    mem_ce_n   = !active;
    mem_adv_n  = !active;
    mem_we_n   = !(strobe && op_q.is_wr);
    mem_oe_n   = !(strobe && !op_q.is_wr);
    mem_cre    = active && op_q.cre;
    mem_addr   = active ? op_q.addr : '0;
    mem_dq_oe  = active && (ph != PH_ADDR) && op_q.is_wr && !op_q.cre;
    mem_dq_out = mem_dq_oe ? op_q.data : '0;
    mem_be_n   = active ? 2'b00 : 2'b11;
  end
endmodule

// File: rtl/cfgprog_sequencer.sv
module cfgprog_sequencer
  import cfgprog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_use_seq,
  input  logic              req_sel_bus,
  input  logic [MEM_DW-1:0] req_value,
  input  logic              eng_idle,
  input  logic              cyc_done,
  output logic              cyc_start,
  output mem_op_t           op,
  output logic              done,
  output logic              commit,
  output logic              commit_sel,
  output logic [MEM_DW-1:0] commit_val
);
  seq_state_t        state;
  logic [IDX_W-1:0]  idx;
  logic              use_seq_q;
  logic              sel_q;
  logic [MEM_DW-1:0] val_q;
  logic              last;
  logic              take;

  assign req_ready  = init_done && (state == SQ_IDLE);
  assign take       = req_valid && req_ready;
  assign last       = use_seq_q ? (idx == IDX_W'(SEQ_CYCLES - 1)) : (idx == '0);
  assign cyc_start  = (state == SQ_RUN) && eng_idle;
  assign commit     = (state == SQ_RUN) && cyc_done && last;
  assign commit_sel = sel_q;
  assign commit_val = val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      idx       <= '0;
      use_seq_q <= 1'b0;
      sel_q     <= 1'b0;
      val_q     <= '0;
      done      <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (take) begin
            use_seq_q <= req_use_seq;
            sel_q     <= req_sel_bus;
            val_q     <= req_value;
            idx       <= '0;
            done      <= 1'b0;
            state     <= SQ_RUN;
          end
        end
        SQ_RUN: begin
          if (cyc_done) begin
            if (last) begin
              done  <= 1'b1;
              state <= SQ_IDLE;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    op = '0;
    if (use_seq_q) begin
      op.addr = '1;
      case (idx)
        IDX_W'(2): begin
          op.is_wr = 1'b1;
          op.data  = {{(MEM_DW-1){1'b0}}, sel_q};
        end
        IDX_W'(3): begin
          op.is_wr = 1'b1;
          op.data  = val_q;
        end
        default: op.is_wr = 1'b0;
      endcase
    end else begin
      op.is_wr              = 1'b1;
      op.cre                = 1'b1;
      op.addr[MEM_DW-1:0]   = val_q;
      op.addr[SEL_ADDR_BIT] = sel_q;
    end
  end
endmodule

// File: rtl/cfgprog_shadow.sv
module cfgprog_shadow
  import cfgprog_pkg::*;
#(
  parameter logic [MEM_DW-1:0] BUS_RESET = 16'h9D4F,
  parameter logic [MEM_DW-1:0] REF_RESET = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              commit_sel,
  input  logic [MEM_DW-1:0] commit_val,
  output logic [MEM_DW-1:0] bus_q,
  output logic [MEM_DW-1:0] ref_q
);
  logic [1:0][MEM_DW-1:0] word_q;

  for (genvar g = 0; g < 2; g++) begin : g_word
    localparam logic [MEM_DW-1:0] RST = (g == 1) ? BUS_RESET : REF_RESET;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g] <= RST;
      end else if (commit && (commit_sel == (g == 1))) begin
        word_q[g] <= commit_val;
      end
    end
  end

  assign bus_q = word_q[1];
  assign ref_q = word_q[0];
endmodule

// File: rtl/cfgreg_prog.sv
module cfgreg_prog
  import cfgprog_pkg::*;
#(
  parameter int                INIT_CYCLES   = 15000,
  parameter int                STROBE_CYCLES = 3,
  parameter logic [MEM_DW-1:0] BUS_RESET     = 16'h9D4F,
  parameter logic [MEM_DW-1:0] REF_RESET     = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_use_seq,
  input  logic              req_sel_bus,
  input  logic [MEM_DW-1:0] req_value,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [MEM_DW-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              mem_cre,
  output logic              mem_ce_n,
  output logic              mem_adv_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [1:0]        mem_be_n,
  output logic              done,
  output logic [MEM_DW-1:0] bus_cfg,
  output logic [MEM_DW-1:0] ref_cfg,
  output logic              cfg_sync,
  output logic [2:0]        cfg_latency,
  output logic              cfg_drive_low,
  output logic              cfg_page_en,
  output logic [2:0]        cfg_par
);
  logic              init_done;
  logic              eng_idle;
  logic              cyc_done;
  logic              cyc_start;
  mem_op_t           op;
  logic              commit;
  logic              commit_sel;
  logic [MEM_DW-1:0] commit_val;

  cfgprog_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_done (init_done)
  );

  cfgprog_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_done   (init_done),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_use_seq (req_use_seq),
    .req_sel_bus (req_sel_bus),
    .req_value   (req_value),
    .eng_idle    (eng_idle),
    .cyc_done    (cyc_done),
    .cyc_start   (cyc_start),
    .op          (op),
    .done        (done),
    .commit      (commit),
    .commit_sel  (commit_sel),
    .commit_val  (commit_val)
  );

  cfgprog_cycle_engine #(.STROBE_CYCLES(STROBE_CYCLES)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (cyc_start),
    .op         (op),
    .idle       (eng_idle),
    .cyc_done   (cyc_done),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_cre    (mem_cre),
    .mem_ce_n   (mem_ce_n),
    .mem_adv_n  (mem_adv_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_be_n   (mem_be_n)
  );

  cfgprog_shadow #(.BUS_RESET(BUS_RESET), .REF_RESET(REF_RESET)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .commit_sel (commit_sel),
    .commit_val (commit_val),
    .bus_q      (bus_cfg),
    .ref_q      (ref_cfg)
  );

  assign cfg_sync      = !bus_cfg[BUS_MODE_BIT];
  assign cfg_latency   = bus_cfg[BUS_LAT_HI:BUS_LAT_LO];
  assign cfg_drive_low = bus_cfg[BUS_DRV_BIT];
  assign cfg_page_en   = ref_cfg[REF_PAGE_BIT];
  assign cfg_par       = ref_cfg[REF_PAR_HI:0];
endmodule

// File: rtl/cfgreg_prog_chk.sv
module cfgreg_prog_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        init_done,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_ce_n,
  input logic        mem_adv_n,
  input logic        mem_we_n,
  input logic        mem_oe_n,
  input logic        mem_cre,
  input logic        done,
  input logic [15:0] bus_cfg,
  input logic [15:0] ref_cfg
);
  AST_NO_CYCLE_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> mem_ce_n); // R1

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready); // R2

  AST_CRE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cre |-> (!mem_ce_n && mem_oe_n)); // R3

  AST_WE_EDGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && !mem_adv_n)); // R5

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(req_valid && req_ready)) |=> done); // R6

  AST_BUS_WORD_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_cfg) |-> $rose(done)); // R7

  AST_REF_WORD_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_cfg) |-> $rose(done)); // R7

  AST_NO_STROBE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n)); // R9
endmodule

bind cfgreg_prog cfgreg_prog_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .init_done (init_done),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_ce_n  (mem_ce_n),
  .mem_adv_n (mem_adv_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_cre   (mem_cre),
  .done      (done),
  .bus_cfg   (bus_cfg),
  .ref_cfg   (ref_cfg)
);

// File: tb/cfgreg_prog_tb.sv
`timescale 1ns/1ps
module cfgreg_prog_tb;
  localparam int INIT = 15000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_use_seq = 1'b0;
  logic        req_sel_bus = 1'b0;
  logic [15:0] req_value = '0;
  logic        req_ready;
  logic [19:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe, mem_cre, mem_ce_n, mem_adv_n, mem_we_n, mem_oe_n;
  logic [1:0]  mem_be_n;
  logic        done;
  logic [15:0] bus_cfg, ref_cfg;
  logic        cfg_sync, cfg_drive_low, cfg_page_en;
  logic [2:0]  cfg_latency, cfg_par;

  always #5 clk = ~clk;

  cfgreg_prog #(.INIT_CYCLES(INIT), .STROBE_CYCLES(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_use_seq(req_use_seq), .req_sel_bus(req_sel_bus), .req_value(req_value),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_cre(mem_cre), .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
    .done(done), .bus_cfg(bus_cfg), .ref_cfg(ref_cfg), .cfg_sync(cfg_sync),
    .cfg_latency(cfg_latency), .cfg_drive_low(cfg_drive_low),
    .cfg_page_en(cfg_page_en), .cfg_par(cfg_par)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bus monitor: rebuilds cycles from the pins
  logic        ev_wr [8];
  logic        ev_cre[8];
  logic [19:0] ev_addr[8];
  logic [15:0] ev_data[8];
  logic        ev_oe [8];
  int          ev_cnt = 0;
  int          ce_falls = 0;
  int          mon_err = 0;
  logic        prev_we = 1'b1, prev_oe = 1'b1, prev_ce = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!prev_we && mem_we_n) begin
        if (mem_ce_n || mem_adv_n) mon_err++;
        if (ev_cnt < 8) begin
          ev_wr[ev_cnt] = 1'b1; ev_cre[ev_cnt] = mem_cre;
          ev_addr[ev_cnt] = mem_addr; ev_data[ev_cnt] = mem_dq_out;
          ev_oe[ev_cnt] = mem_dq_oe;
        end
        ev_cnt++;
      end
      if (prev_oe && !mem_oe_n) begin
        if (ev_cnt < 8) begin
          ev_wr[ev_cnt] = 1'b0; ev_cre[ev_cnt] = mem_cre;
          ev_addr[ev_cnt] = mem_addr; ev_data[ev_cnt] = '0;
          ev_oe[ev_cnt] = mem_dq_oe;
        end
        ev_cnt++;
      end
      if (prev_ce && !mem_ce_n) ce_falls++;
      if (!mem_ce_n && mem_be_n != 2'b00) mon_err++;
      if (!mem_we_n && !mem_oe_n) mon_err++;
      if (mem_cre && mem_dq_oe) mon_err++;
    end
    prev_we = mem_we_n; prev_oe = mem_oe_n; prev_ce = mem_ce_n;
  end

  logic [15:0] exp_bus = 16'h9D4F;
  logic [15:0] exp_ref = 16'h0010;

  task automatic check_shadow(input string tag);
    chk(bus_cfg == exp_bus, "R7", {tag, " bus word"}, 32'(bus_cfg), 32'(exp_bus));
    chk(ref_cfg == exp_ref, "R7", {tag, " refresh word"}, 32'(ref_cfg), 32'(exp_ref));
    chk(cfg_sync == !exp_bus[15], "R8", {tag, " sync"}, 32'(cfg_sync), 32'(!exp_bus[15]));
    chk(cfg_latency == 3'((exp_bus >> 11) & 16'h7), "R8", {tag, " latency"},
        32'(cfg_latency), 32'((exp_bus >> 11) & 16'h7));
    chk(cfg_drive_low == exp_bus[5], "R8", {tag, " drive"}, 32'(cfg_drive_low), 32'(exp_bus[5]));
    chk(cfg_page_en == exp_ref[7], "R8", {tag, " page"}, 32'(cfg_page_en), 32'(exp_ref[7]));
    chk(cfg_par == 3'(exp_ref & 16'h7), "R8", {tag, " par"}, 32'(cfg_par), 32'(exp_ref & 16'h7));
  endtask

  task automatic prog(input bit m, input bit s, input logic [15:0] v);
    int n;
    int saw;
    @(negedge clk);
    ev_cnt = 0; ce_falls = 0; mon_err = 0;
    chk(req_ready == 1'b1, "R2", "ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_use_seq = m; req_sel_bus = s; req_value = v;
    @(negedge clk);
    req_valid = 1'b0; req_use_seq = !m; req_sel_bus = !s; req_value = ~v;
    chk(req_ready == 1'b0, "R2", "ready low while busy", 32'(req_ready), 32'd0);
    chk(done == 1'b0, "R6", "done cleared on transfer", 32'(done), 32'd0);
    saw = 0;
    for (int i = 0; i < 100; i++) begin
      if (done) begin saw = 1; break; end
      @(negedge clk);
    end
    chk(saw == 1, "R6", "done rises", 32'(saw), 32'd1);
    chk(mem_ce_n == 1'b1, "R6", "cycle over at done", 32'(mem_ce_n), 32'd1);
    n = m ? 4 : 1;
    chk(ev_cnt == n, "R2", "cycle count", 32'(ev_cnt), 32'(n));
    chk(ce_falls == n, "R5", "separate chip-enable cycles", 32'(ce_falls), 32'(n));
    chk(mon_err == 0, "R5", "edge order, byte enables, R9 strobe rules", 32'(mon_err), 32'd0);
    if (!m) begin
      chk(ev_wr[0] && ev_cre[0] && !ev_oe[0], "R3", "sideband write kind",
          32'({ev_wr[0], ev_cre[0], ev_oe[0]}), 32'b110);
      chk(ev_addr[0] == {s, 3'b000, v}, "R3", "sideband address",
          32'(ev_addr[0]), 32'({s, 3'b000, v}));
    end else begin
      for (int k = 0; k < 4; k++) begin
        chk(ev_addr[k] == 20'hFFFFF && !ev_cre[k], "R4", "top address, enable low",
            32'({ev_cre[k], ev_addr[k]}), 32'h000FFFFF);
        chk(ev_wr[k] == (k >= 2), "R4", "read/write order", 32'(ev_wr[k]), 32'(k >= 2));
      end
      chk(ev_oe[2] && ev_data[2] == 16'(s), "R4", "selector code",
          32'({ev_oe[2], ev_data[2]}), 32'({1'b1, 16'(s)}));
      chk(ev_oe[3] && ev_data[3] == v, "R4", "value write",
          32'({ev_oe[3], ev_data[3]}), 32'({1'b1, v}));
    end
    if (s) exp_bus = v; else exp_ref = v;
    check_shadow("after write");
    repeat (3) @(negedge clk);
    chk(ev_cnt == n && done, "R2", "no cycle without request",
        32'({done, 8'(ev_cnt)}), 32'({1'b1, 8'(n)}));
  endtask

  initial begin
    int ce_low;
    ce_low = 0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_cre, "R1", "pins idle in reset",
        32'({mem_ce_n, mem_we_n, mem_oe_n, mem_cre}), 32'b1110);
    chk(!req_ready && !done, "R6", "ready/done low in reset", 32'({req_ready, done}), 32'd0);
    check_shadow("reset");
    rst_n = 1'b1;
    for (int k = 1; k <= INIT; k++) begin
      @(negedge clk);
      if (!mem_ce_n) ce_low++;
      if (k == INIT - 1)
        chk(req_ready == 1'b0, "R1", "ready low one edge before end of wait", 32'(req_ready), 32'd0);
      if (k == INIT)
        chk(req_ready == 1'b1, "R1", "ready at end of wait", 32'(req_ready), 32'd1);
    end
    chk(ce_low == 0, "R1", "no chip enable during wait", 32'(ce_low), 32'd0);
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 2; s++) begin
        prog(m[0], s[0], 16'h0000);
        prog(m[0], s[0], 16'hFFFF);
        prog(m[0], s[0], 16'h9D4F);
        prog(m[0], s[0], 16'h5AA5);
        for (int b = 0; b < 16; b++) prog(m[0], s[0], 16'(1 << b));
      end
    end
    prog(1'b1, 1'b1, 16'h1F25);
    prog(1'b0, 1'b0, 16'h0083);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1900000;
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule